// File: doc/BRIEF.md
# Turnaround Three-Wire SPI Host

This block is the host end of a three-wire serial link. Clock, one data wire and an active-low select are each bidirectional, and the two ends take turns as master. A command of one or two bytes is accepted on a valid/ready port. The host sends it as master, with each byte framed by its own select pulse and a minimum gap enforced between the two bytes. It then lets go of all three lines and listens as a slave while the peripheral clocks back a stated number of response bytes. Each response byte is held in a register with a valid/ready handshake.

Each line has an output value and an output enable, and the pad ring builds the tristate buffer. During the response phase the three pins are resynchronised. A byte that completes while the previous one is still waiting is dropped and reported with a one-cycle overrun pulse. A sequence ends when the expected number of bytes has arrived, or when the line stays silent for a set number of cycles, which raises a timeout pulse. A quiet period then holds off the next command.

Top module: `tw_spi_host`

## Requirements
- R1: After reset and whenever the block is idle, all three output enables are low and `cmd_ready_o` is high once the quiet period has elapsed. Directly after reset there is no quiet period.
- R2: During the command phase all three enables are high, and `ss_n_o` changes only while `sck_o` is low and was low in the previous cycle. `ss_n_o` goes low on the clock edge that follows the command handshake.
- R3: Command bits go out MSB first. `sd_o` changes only when `sck_o` falls, and it is stable while `sck_o` is high, so the peripheral samples it on the rising edge.
- R4: Each command byte has its own low select pulse, which contains exactly eight rising edges of `sck_o`.
- R5: When `cmd_two_i` is 1, at least BYTE_GAP clock cycles pass between `ss_n_o` returning high after the first byte and `ss_n_o` going low for the second byte.
- R6: Once the last command byte's select has gone high, all three enables drop within HALF_CYC+1 cycles and stay low for the rest of the sequence.
- R7: In the response phase, a rising edge of the synchronised `sck_i` while the synchronised `ss_n_i` is low shifts in `sd_i`, MSB first. `rsp_valid_o` rises 4 clock cycles after the pin-level rise of the eighth clock edge. A high `ss_n_i` clears a partial byte.
- R8: `rsp_valid_o` and `rsp_data_o` hold until `rsp_ready_i` is sampled high. A byte that completes while an unconsumed byte is held is dropped, and `rsp_overrun_o` pulses for one cycle.
- R9: The sequence ends on the byte that completes the count given in `cmd_rsp_cnt_i`, with dropped bytes included. `seq_done_o` pulses in the same cycle that the last byte's valid would appear. A count of 0 ends the sequence when the last command byte is released.
- R10: If RSP_TIMEOUT cycles pass with no completed byte, counted from entry to the response phase or from the last byte, `seq_timeout_o` and `seq_done_o` pulse together. This happens RSP_TIMEOUT+4 cycles after the last byte's eighth clock edge on the pin.
- R11: After `seq_done_o`, `cmd_ready_o` stays low for SEQ_GAP cycles. With a command already waiting, `ss_n_o` falls exactly SEQ_GAP+1 cycles after `seq_done_o`.
- R12: Activity on `sck_i`, `sd_i` and `ss_n_i` outside the response phase produces no response byte, no overrun and no later corruption.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command accepted this cycle if valid |
| cmd_two_i | input | 1 | 1: two command bytes, 0: one |
| cmd_byte0_i | input | 8 | First command byte |
| cmd_byte1_i | input | 8 | Second command byte |
| cmd_rsp_cnt_i | input | CNT_W | Number of response bytes expected |
| rsp_valid_o | output | 1 | Response byte held |
| rsp_ready_i | input | 1 | Response byte consumed |
| rsp_data_o | output | 8 | Response byte |
| rsp_overrun_o | output | 1 | Pulse: a response byte was dropped |
| seq_done_o | output | 1 | Pulse: sequence finished |
| seq_timeout_o | output | 1 | Pulse: sequence finished by silence timeout |
| sck_i | input | 1 | Clock pin input |
| sck_o | output | 1 | Clock pin drive value |
| sck_oe_o | output | 1 | Clock pin drive enable |
| sd_i | input | 1 | Data pin input |
| sd_o | output | 1 | Data pin drive value |
| sd_oe_o | output | 1 | Data pin drive enable |
| ss_n_i | input | 1 | Select pin input |
| ss_n_o | output | 1 | Select pin drive value |
| ss_n_oe_o | output | 1 | Select pin drive enable |

## Verification
On the command side, the select goes low one cycle after the handshake edge. A second byte starts HALF_CYC+BYTE_GAP cycles after the first select rises, and a waiting command starts SEQ_GAP+1 cycles after `seq_done_o`. A response byte's valid and a sequence end appear 4 cycles after the eighth pin clock edge, which covers two synchroniser stages, the edge detector and the holding register. A timeout appears RSP_TIMEOUT+4 cycles after that edge. The bench drives the pins on falling clock edges and samples outputs 2 ns after each rising edge. It stamps every event with a cycle count and compares the differences with these exact figures, or with the stated lower bound for the byte gap. It checks held and ignored states only after the stimulus has ended and before the next one begins.

// File: rtl/tw_spi_pkg.sv
package tw_spi_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_TX0, SQ_BGAP, SQ_TX1, SQ_RSP
  } seq_state_e;

  typedef enum logic [2:0] {
    TX_IDLE, TX_LEAD, TX_HIGH, TX_LOW, TX_TRAIL
  } tx_state_e;
endpackage

// File: rtl/tw_spi_tx.sv
module tw_spi_tx
  import tw_spi_pkg::*;
#(
  parameter int unsigned HALF_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              done_o,
  output logic              sck_o,
  output logic              sd_o,
  output logic              ss_n_o
);
  localparam int unsigned HW = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);
  localparam int unsigned BW = $clog2(BYTE_W + 1);

  tx_state_e         st_q;
  logic [HW-1:0]     cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BW-1:0]     bits_q;
  logic              phase_end;
  logic              framed;

  assign phase_end = (cnt_q == HW'(HALF_CYC - 1));
  assign framed    = (st_q == TX_LEAD) || (st_q == TX_HIGH) || (st_q == TX_LOW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TX_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      bits_q <= '0;
    end else if (st_q == TX_IDLE) begin
      if (start_i) begin
        sh_q   <= byte_i;
        bits_q <= '0;
        cnt_q  <= '0;
        st_q   <= TX_LEAD;
      end
    end else if (!phase_end) begin
      cnt_q <= cnt_q + HW'(1);
    end else begin
      cnt_q <= '0;
      unique case (st_q)
        TX_LEAD: st_q <= TX_HIGH;
        TX_HIGH: begin
          // falling edge: next bit onto the wire
          sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
          bits_q <= bits_q + BW'(1);
          st_q   <= TX_LOW;
        end
        TX_LOW:   st_q <= (bits_q == BW'(BYTE_W)) ? TX_TRAIL : TX_HIGH;
        TX_TRAIL: st_q <= TX_IDLE;
        default:  st_q <= TX_IDLE;
      endcase
    end
  end

  assign sck_o  = (st_q == TX_HIGH);
  assign ss_n_o = !framed;
  assign sd_o   = framed & sh_q[BYTE_W-1];
  assign done_o = (st_q == TX_TRAIL) && phase_end;
endmodule

// File: rtl/tw_spi_rx.sv
module tw_spi_rx
  import tw_spi_pkg::*;
#(
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sck_i,
  input  logic              sd_i,
  input  logic              ss_n_i,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int unsigned BW = $clog2(BYTE_W);
  localparam logic [2:0] PIN_RST = 3'b100; // {ss_n, sd, sck}

  logic [2:0]        sync_q [SYNC_N];
  logic              sck_s, sd_s, ss_s, sck_d;
  logic              rise;
  logic [BYTE_W-1:0] sh_q;
  logic [BW-1:0]     bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SYNC_N; i++) sync_q[i] <= PIN_RST;
      sck_d <= 1'b0;
    end else begin
      sync_q[0] <= {ss_n_i, sd_i, sck_i};
      for (int i = 1; i < SYNC_N; i++) sync_q[i] <= sync_q[i-1];
      sck_d <= sck_s;
    end
  end

  assign {ss_s, sd_s, sck_s} = sync_q[SYNC_N-1];
  assign rise = sck_s & !sck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q         <= '0;
      bits_q       <= '0;
      byte_o       <= '0;
      byte_valid_o <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      if (!en_i || ss_s) begin
        bits_q <= '0;
      end else if (rise) begin
        sh_q <= {sh_q[BYTE_W-2:0], sd_s};
        if (bits_q == BW'(BYTE_W - 1)) begin
          bits_q       <= '0;
          byte_o       <= {sh_q[BYTE_W-2:0], sd_s};
          byte_valid_o <= 1'b1;
        end else begin
          bits_q <= bits_q + BW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/tw_spi_rsp_buf.sv
module tw_spi_rsp_buf
  import tw_spi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              overrun_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      data_o    <= '0;
      overrun_o <= 1'b0;
    end else begin
      overrun_o <= load_i && valid_o && !ready_i;
      if (load_i && (!valid_o || ready_i)) begin
        data_o  <= data_i;
        valid_o <= 1'b1;
      end else if (valid_o && ready_i) begin
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tw_spi_seq.sv
module tw_spi_seq
  import tw_spi_pkg::*;
#(
  parameter int unsigned BYTE_GAP    = 6250,
  parameter int unsigned SEQ_GAP     = 125000,
  parameter int unsigned RSP_TIMEOUT = 250000,
  parameter int unsigned CNT_W       = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_two_i,
  input  logic [BYTE_W-1:0] cmd_byte0_i,
  input  logic [BYTE_W-1:0] cmd_byte1_i,
  input  logic [CNT_W-1:0]  cmd_rsp_cnt_i,
  output logic              tx_start_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  input  logic              tx_done_i,
  output logic              rx_en_o,
  input  logic              rx_byte_valid_i,
  output logic              drive_o,
  output logic              seq_done_o,
  output logic              seq_timeout_o
);
  localparam int unsigned GW = $clog2(BYTE_GAP + 1);
  localparam int unsigned QW = $clog2(SEQ_GAP + 1);
  localparam int unsigned TW = $clog2(RSP_TIMEOUT + 1);

  seq_state_e        st_q;
  logic              two_q;
  logic [BYTE_W-1:0] b1_q;
  logic [CNT_W-1:0]  left_q;
  logic [GW-1:0]     gap_q;
  logic [QW-1:0]     quiet_q;
  logic [TW-1:0]     wait_q;
  logic              accept;

  assign cmd_ready_o = (st_q == SQ_IDLE) && (quiet_q == '0);
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign tx_start_o  = accept || ((st_q == SQ_BGAP) && (gap_q == '0));
  assign tx_byte_o   = (st_q == SQ_IDLE) ? cmd_byte0_i : b1_q;
  assign drive_o     = (st_q == SQ_TX0) || (st_q == SQ_BGAP) || (st_q == SQ_TX1);
  assign rx_en_o     = (st_q == SQ_RSP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= SQ_IDLE;
      two_q         <= 1'b0;
      b1_q          <= '0;
      left_q        <= '0;
      gap_q         <= '0;
      quiet_q       <= '0;
      wait_q        <= '0;
      seq_done_o    <= 1'b0;
      seq_timeout_o <= 1'b0;
    end else begin
      seq_done_o    <= 1'b0;
      seq_timeout_o <= 1'b0;
      if (quiet_q != '0) quiet_q <= quiet_q - QW'(1);
      unique case (st_q)
        SQ_IDLE: if (accept) begin
          two_q  <= cmd_two_i;
          b1_q   <= cmd_byte1_i;
          left_q <= cmd_rsp_cnt_i;
          st_q   <= SQ_TX0;
        end
        SQ_TX0, SQ_TX1: if (tx_done_i) begin
          if ((st_q == SQ_TX0) && two_q) begin
            gap_q <= GW'(BYTE_GAP - 1);
            st_q  <= SQ_BGAP;
          end else if (left_q == '0) begin
            st_q       <= SQ_IDLE;
            seq_done_o <= 1'b1;
            quiet_q    <= QW'(SEQ_GAP);
          end else begin
            wait_q <= '0;
            st_q   <= SQ_RSP;
          end
        end
        SQ_BGAP: begin
          if (gap_q == '0) st_q <= SQ_TX1;
          else             gap_q <= gap_q - GW'(1);
        end
        SQ_RSP: begin
          if (rx_byte_valid_i) begin
            wait_q <= '0;
            if (left_q == CNT_W'(1)) begin
              st_q       <= SQ_IDLE;
              seq_done_o <= 1'b1;
              quiet_q    <= QW'(SEQ_GAP);
            end
            left_q <= left_q - CNT_W'(1);
          end else if (wait_q == TW'(RSP_TIMEOUT - 1)) begin
            st_q          <= SQ_IDLE;
            seq_done_o    <= 1'b1;
            seq_timeout_o <= 1'b1;
            quiet_q       <= QW'(SEQ_GAP);
          end else begin
            wait_q <= wait_q + TW'(1);
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tw_spi_host.sv
module tw_spi_host
  import tw_spi_pkg::*;
#(
  parameter int unsigned HALF_CYC    = 8,
  parameter int unsigned BYTE_GAP    = 6250,
  parameter int unsigned SEQ_GAP     = 125000,
  parameter int unsigned RSP_TIMEOUT = 250000,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SYNC_N      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_two_i,
  input  logic [BYTE_W-1:0] cmd_byte0_i,
  input  logic [BYTE_W-1:0] cmd_byte1_i,
  input  logic [CNT_W-1:0]  cmd_rsp_cnt_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [BYTE_W-1:0] rsp_data_o,
  output logic              rsp_overrun_o,
  output logic              seq_done_o,
  output logic              seq_timeout_o,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              sd_i,
  output logic              sd_o,
  output logic              sd_oe_o,
  input  logic              ss_n_i,
  output logic              ss_n_o,
  output logic              ss_n_oe_o
);
  logic              tx_start, tx_done, drive;
  logic [BYTE_W-1:0] tx_byte;
  logic              rx_en, rx_valid;
  logic [BYTE_W-1:0] rx_byte;

  tw_spi_seq #(
    .BYTE_GAP   (BYTE_GAP),
    .SEQ_GAP    (SEQ_GAP),
    .RSP_TIMEOUT(RSP_TIMEOUT),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cmd_valid_i    (cmd_valid_i),
    .cmd_ready_o    (cmd_ready_o),
    .cmd_two_i      (cmd_two_i),
    .cmd_byte0_i    (cmd_byte0_i),
    .cmd_byte1_i    (cmd_byte1_i),
    .cmd_rsp_cnt_i  (cmd_rsp_cnt_i),
    .tx_start_o     (tx_start),
    .tx_byte_o      (tx_byte),
    .tx_done_i      (tx_done),
    .rx_en_o        (rx_en),
    .rx_byte_valid_i(rx_valid),
    .drive_o        (drive),
    .seq_done_o     (seq_done_o),
    .seq_timeout_o  (seq_timeout_o)
  );

  tw_spi_tx #(.HALF_CYC(HALF_CYC)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tx_start),
    .byte_i (tx_byte),
    .done_o (tx_done),
    .sck_o  (sck_o),
    .sd_o   (sd_o),
    .ss_n_o (ss_n_o)
  );

  tw_spi_rx #(.SYNC_N(SYNC_N)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (rx_en),
    .sck_i       (sck_i),
    .sd_i        (sd_i),
    .ss_n_i      (ss_n_i),
    .byte_valid_o(rx_valid),
    .byte_o      (rx_byte)
  );

  tw_spi_rsp_buf u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (rx_valid),
    .data_i   (rx_byte),
    .ready_i  (rsp_ready_i),
    .valid_o  (rsp_valid_o),
    .data_o   (rsp_data_o),
    .overrun_o(rsp_overrun_o)
  );

  assign sck_oe_o  = drive;
  assign sd_oe_o   = drive;
  assign ss_n_oe_o = drive;
endmodule

// File: rtl/tw_spi_host_chk.sv
module tw_spi_host_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_ready_o,
  input logic       sck_o,
  input logic       sck_oe_o,
  input logic       sd_o,
  input logic       sd_oe_o,
  input logic       ss_n_o,
  input logic       ss_n_oe_o,
  input logic       rsp_valid_o,
  input logic       rsp_ready_i,
  input logic [7:0] rsp_data_o,
  input logic       rsp_overrun_o,
  input logic       seq_done_o,
  input logic       seq_timeout_o
);
  p_idle_released_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !(sck_oe_o || sd_oe_o || ss_n_oe_o));

  p_ss_edge_sck_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_n_oe_o && !$stable(ss_n_o)) |-> (!sck_o && !$past(sck_o)));

  p_data_hold_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_oe_o && sck_o && $past(sck_o)) |-> $stable(sd_o));

  p_release_at_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_o |-> !(sck_oe_o || sd_oe_o || ss_n_oe_o));

  p_rsp_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o)));

  p_overrun_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_overrun_o |-> $past(rsp_valid_o && !rsp_ready_i));

  p_timeout_ends_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_timeout_o |-> seq_done_o);

  p_quiet_after_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_o |=> !cmd_ready_o);
endmodule

bind tw_spi_host tw_spi_host_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_ready_o  (cmd_ready_o),
  .sck_o        (sck_o),
  .sck_oe_o     (sck_oe_o),
  .sd_o         (sd_o),
  .sd_oe_o      (sd_oe_o),
  .ss_n_o       (ss_n_o),
  .ss_n_oe_o    (ss_n_oe_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_ready_i  (rsp_ready_i),
  .rsp_data_o   (rsp_data_o),
  .rsp_overrun_o(rsp_overrun_o),
  .seq_done_o   (seq_done_o),
  .seq_timeout_o(seq_timeout_o)
);

// File: tb/tw_spi_host_tb_top.sv
`timescale 1ns/1ps
module tw_spi_host_tb_top;
  localparam int HC = 3;
  localparam int BG = 40;
  localparam int SG = 150;
  localparam int RT = 500;
  localparam int CW = 4;
  localparam int PH = 6;    // peripheral half period in clk cycles
  localparam int NV = 4;
  // {two[39:36], b0[35:28], b1[27:20], n[19:16], r0[15:8], r1[7:0]}
  localparam logic [39:0] VEC [NV] = '{
    40'h0_A5_00_1_3C_00,
    40'h1_81_7E_2_C3_5A,
    40'h1_00_FF_0_00_00,
    40'h0_96_00_2_01_80
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_two = 0, rsp_ready = 1;
  logic [7:0] b0 = 0, b1 = 0;
  logic [CW-1:0] rcnt = 0;
  logic p_sck = 0, p_sd = 0, p_ss_n = 1;
  logic cmd_ready, rsp_valid, rsp_overrun, seq_done, seq_timeout;
  logic [7:0] rsp_data;
  logic sck_o, sck_oe, sd_o, sd_oe, ss_n_o, ss_n_oe;

  always #4 clk = ~clk;

  tw_spi_host #(
    .HALF_CYC(HC), .BYTE_GAP(BG), .SEQ_GAP(SG), .RSP_TIMEOUT(RT), .CNT_W(CW), .SYNC_N(2)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_two_i(cmd_two),
    .cmd_byte0_i(b0), .cmd_byte1_i(b1), .cmd_rsp_cnt_i(rcnt),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_data_o(rsp_data),
    .rsp_overrun_o(rsp_overrun), .seq_done_o(seq_done), .seq_timeout_o(seq_timeout),
    .sck_i(p_sck), .sck_o(sck_o), .sck_oe_o(sck_oe),
    .sd_i(p_sd), .sd_o(sd_o), .sd_oe_o(sd_oe),
    .ss_n_i(p_ss_n), .ss_n_o(ss_n_o), .ss_n_oe_o(ss_n_oe)
  );

  int checks = 0, errs = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // observer: command frames and result events
  logic [7:0] cap = 0, fr_byte [32], got [32];
  int fr_edges [32], fall_cyc [32], rise_cyc [32];
  int nfr = 0, edges = 0, ngot = 0, ndone = 0, nto = 0, novr = 0;
  int done_cyc = 0, to_cyc = 0, vrise_cyc = 0, rise8_cyc = 0;
  logic sck_p = 0, ss_p = 1, v_p = 0;

  always begin
    @(posedge clk); #2;
    if (sck_oe && !ss_n_o && sck_o && !sck_p) begin cap = {cap[6:0], sd_o}; edges++; end
    if (ss_n_oe && !ss_n_o && ss_p) begin fall_cyc[nfr] = cyc; edges = 0; end
    if (ss_n_oe && ss_n_o && !ss_p) begin
      fr_byte[nfr] = cap; fr_edges[nfr] = edges; rise_cyc[nfr] = cyc; nfr++;
    end
    sck_p = sck_o; ss_p = ss_n_o;
    if (rsp_valid && !v_p) vrise_cyc = cyc;
    v_p = rsp_valid;
    if (rsp_valid && rsp_ready) begin got[ngot] = rsp_data; ngot++; end
    if (seq_done) begin ndone++; done_cyc = cyc; end
    if (seq_timeout) begin nto++; to_cyc = cyc; end
    if (rsp_overrun) novr++;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_ge(string req, string what, int act, int lo);
    checks++;
    if (act < lo) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected>=%0d", req, what, act, lo);
    end
  endtask

  task automatic issue(bit two, logic [7:0] x0, logic [7:0] x1, int n);
    int g;
    @(negedge clk);
    cmd_valid = 1; cmd_two = two; b0 = x0; b1 = x1; rcnt = CW'(n);
    g = 0;
    while (!cmd_ready && g < 5000) begin @(negedge clk); g++; end
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_frames(int target);
    int g = 0;
    while (nfr < target && g < 5000) begin @(negedge clk); g++; end
  endtask

  task automatic send_rsp(logic [7:0] d);
    @(negedge clk);
    p_ss_n = 0;
    tick(PH);
    for (int i = 7; i >= 0; i--) begin
      p_sd = d[i];
      tick(PH);
      p_sck = 1;
      if (i == 0) rise8_cyc = cyc;
      tick(PH);
      p_sck = 0;
    end
    tick(PH);
    p_ss_n = 1;
    tick(PH);
  endtask

  initial begin
    #(8 * 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int base_fr, base_got, base_done, last_done, nb, n, g, ovr0, got0;
    logic [39:0] v;
    tick(3);
    check("R1", "oe in reset", {sck_oe, sd_oe, ss_n_oe}, 0);
    rst_n = 1;
    tick(2);
    check("R1", "ready after reset", cmd_ready, 1);
    check("R1", "oe idle", {sck_oe, sd_oe, ss_n_oe}, 0);
    check("R1", "no rsp after reset", {rsp_valid, seq_done}, 0);

    // vector walk: R2 R3 R4 R5 R6 R7 R9 R11
    last_done = 0;
    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      nb = v[36] ? 2 : 1;
      n = int'(v[19:16]);
      base_fr = nfr; base_got = ngot; base_done = ndone;
      issue(v[36], v[35:28], v[27:20], n);
      wait_frames(base_fr + nb);
      check("R3", "cmd byte0", fr_byte[base_fr], v[35:28]);
      check("R4", "edges byte0", fr_edges[base_fr], 8);
      if (nb == 2) begin
        check("R3", "cmd byte1", fr_byte[base_fr + 1], v[27:20]);
        check("R4", "edges byte1", fr_edges[base_fr + 1], 8);
        check_ge("R5", "byte gap", fall_cyc[base_fr + 1] - rise_cyc[base_fr], BG);
      end
      if (k > 0) check_ge("R11", "seq gap", fall_cyc[base_fr] - last_done, SG + 1);
      tick(HC + 2);
      check("R6", "released after cmd", {sck_oe, sd_oe, ss_n_oe}, 0);
      for (int r = 0; r < n; r++) send_rsp(r == 0 ? v[15:8] : v[7:0]);
      tick(3);
      check("R7", "rsp count", ngot - base_got, n);
      if (n > 0) check("R7", "rsp byte0", got[base_got], v[15:8]);
      if (n > 1) check("R7", "rsp byte1", got[base_got + 1], v[7:0]);
      check("R9", "one seq_done", ndone - base_done, 1);
      check("R10", "no timeout", nto, 0);
      last_done = done_cyc;
    end

    // R7/R8/R9 exact latency with held byte
    g = 0; while (!cmd_ready && g < 1000) begin tick(1); g++; end
    base_fr = nfr; base_done = ndone;
    issue(0, 8'h11, 8'h00, 1);
    wait_frames(base_fr + 1);
    tick(HC + 2);
    rsp_ready = 0;
    send_rsp(8'hE7);
    check("R7", "valid latency", vrise_cyc - rise8_cyc, 4);
    check("R9", "done latency", done_cyc - rise8_cyc, 4);
    check("R11", "not ready after done", cmd_ready, 0);
    tick(20);
    check("R8", "valid held", rsp_valid, 1);
    check("R8", "data held", rsp_data, 8'hE7);
    rsp_ready = 1;
    tick(2);
    check("R8", "valid cleared", rsp_valid, 0);

    // R11 exact quiet gap, then R8 overrun
    base_fr = nfr; base_done = ndone; ovr0 = novr;
    issue(0, 8'h5A, 8'h00, 3);
    wait_frames(base_fr + 1);
    check("R11", "quiet exact", fall_cyc[base_fr] - done_cyc, SG + 1);
    tick(HC + 2);
    rsp_ready = 0;
    send_rsp(8'h12);
    send_rsp(8'h34);
    check("R8", "overrun pulse", novr - ovr0, 1);
    check("R8", "first kept", rsp_data, 8'h12);
    send_rsp(8'h56);
    check("R8", "second overrun", novr - ovr0, 2);
    check("R9", "done counts dropped", ndone - base_done, 1);
    check("R8", "still first", rsp_data, 8'h12);
    rsp_ready = 1;
    tick(2);
    check("R8", "consumed", rsp_valid, 0);

    // R10 timeout
    g = 0; while (!cmd_ready && g < 1000) begin tick(1); g++; end
    base_fr = nfr; base_done = ndone; got0 = ngot;
    issue(1, 8'hC0, 8'h03, 2);
    wait_frames(base_fr + 2);
    tick(HC + 2);
    send_rsp(8'h77);
    g = 0; while (nto == 0 && g < RT + 100) begin tick(1); g++; end
    check("R10", "timeout seen", nto, 1);
    check("R10", "timeout latency", to_cyc - rise8_cyc, RT + 4);
    check("R10", "done with timeout", done_cyc, to_cyc);
    check("R10", "partial byte kept", got[got0], 8'h77);

    // R12 line activity while idle is ignored
    got0 = ngot; ovr0 = novr;
    send_rsp(8'hAA);
    tick(4);
    check("R12", "no rsp when idle", rsp_valid, 0);
    check("R12", "no capture when idle", ngot - got0, 0);
    check("R12", "no overrun when idle", novr - ovr0, 0);
    check("R12", "oe idle", {sck_oe, sd_oe, ss_n_oe}, 0);
    g = 0; while (!cmd_ready && g < 1000) begin tick(1); g++; end
    base_fr = nfr;
    issue(0, 8'h3C, 8'h00, 1);
    wait_frames(base_fr + 1);
    tick(HC + 2);
    send_rsp(8'h99);
    tick(3);
    check("R12", "clean rsp after junk", got[ngot - 1], 8'h99);
    check("R12", "one byte after junk", ngot - got0, 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule